// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Pool

This block holds a small pool of reservation stations and a rename table for an out-of-order arithmetic pipeline. Each issued instruction names a destination register and two source registers. At issue, every source is resolved either to its current register value or, when an older instruction still has to write that register, to the number (tag) of the station that will produce it. The destination register's table entry then points at the newly issued station. Later writers therefore take over a register's name, and earlier readers no longer depend on it. This removes write-after-read and write-after-write ordering.

A station whose operands are all present is offered to the functional unit on the execute port. The functional unit accepts it and later raises a per-station completion request together with the result. One completion per cycle is granted onto a single result bus in round-robin order. The granted tag and value are broadcast to all waiting stations and to the register file in the same cycle, and the producing station becomes free. Arithmetic itself lies outside the block: only the offer/accept and request/grant handshakes are modelled. The pool has four stations, eight registers and 32-bit values. All registers hold zero after reset.

Top module: `tag_rs_pool`

## Requirements
- R1: After reset, issueReady is 1, exValid is 0 and cdbValid is 0, and every register reads as value 0 with no pending writer.
- R2: An issue (issueValid with issueReady) takes the lowest-numbered free station (0..3). That number is what exTag later shows for it. issueReady is 0 exactly when all four stations are busy, and an issue presented then changes nothing. A station becomes free again in the cycle after its result is broadcast.
- R3: A source register with no pending writer is copied as a value. A station whose two sources are both of this kind is offered for execution in the cycle after issue, with exVj/exVk equal to the register values of issueSrcA/issueSrcB and exOp equal to issueOp.
- R4: A source register with a pending writer makes the station record that writer's tag. The station is not offered until broadcasts have arrived for every recorded tag, and it then shows the broadcast values on exVj/exVk.
- R5: Issue points the destination register at the issuing station, replacing any older pending writer. A broadcast updates a register only while that register still points at the broadcasting station, so the value of the youngest writer of a register is the one kept.
- R6: When a source's pending writer is broadcast in the same cycle as the issue, the issuing station takes the broadcast value directly and does not wait.
- R7: exValid is 1 when at least one busy station has both operands and has not yet been accepted. exTag then names the lowest-numbered such station. exAccept in a cycle with exValid marks that station as executing, and it is not offered again.
- R8: At most one result is broadcast per cycle, and only for a station that requests it. cdbValue is the 32-bit slice of doneData at bit offset 32 x cdbTag. Among the executing stations that request, the grant goes to the first one found searching upward (wrapping 3 to 0) from the station after the last one granted. The search starts at station 0 after reset.
- R9: A completion request from a station that is free, or busy but not yet accepted for execution, is ignored and produces no broadcast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| issueValid | input | 1 | An instruction is presented for issue |
| issueOp | input | 3 | Operation code carried to the functional unit |
| issueDst | input | 3 | Destination register number |
| issueSrcA | input | 3 | First source register number |
| issueSrcB | input | 3 | Second source register number |
| issueReady | output | 1 | At least one station is free |
| exValid | output | 1 | A station is ready to execute |
| exAccept | input | 1 | Functional unit takes the offered station |
| exTag | output | 2 | Number of the offered station |
| exOp | output | 3 | Operation code of the offered station |
| exVj | output | 32 | First operand of the offered station |
| exVk | output | 32 | Second operand of the offered station |
| doneReq | input | 4 | Per-station completion request |
| doneData | input | 128 | Per-station results, station n at bits 32n+31..32n |
| cdbValid | output | 1 | A result is broadcast this cycle |
| cdbTag | output | 2 | Station whose result is broadcast |
| cdbValue | output | 32 | Broadcast result value |

## Verification
The broadcast outputs respond combinationally to doneReq in the same cycle, so the bench checks cdbValid, cdbTag and cdbValue a moment after driving the request and before the next rising edge. Issue, acceptance and capture are all registered: a newly issued or newly woken station shows up on exValid/exTag/exVj/exVk one cycle after the edge that took the issue or broadcast, and issueReady rises one cycle after the broadcast that frees a station. Register contents are checked only through a later issue that reads them. Every expected operand and register value comes from a model of the register file kept in the bench, including sums of earlier values, and the expected round-robin order is derived from the last granted station.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_NUM  = 4;
  localparam int REG_NUM = 8;
  localparam int DATA_W  = 32;
  localparam int OP_W    = 3;
  localparam int TAG_W   = $clog2(RS_NUM);
  localparam int REG_W   = $clog2(REG_NUM);

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [REG_W-1:0]  regIdx_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [OP_W-1:0]   op_t;

  // pending-producer reference: pend=0 means the value is present
  typedef struct packed {
    logic pend;
    tag_t src;
  } qtag_t;

  // strobes from control to datapath
  typedef struct packed {
    logic alloc;
    tag_t allocIdx;
    logic bcast;
    tag_t bcastIdx;
    tag_t dispIdx;
  } rs_strobe_t;

  function automatic tag_t lowestSet(input logic [RS_NUM-1:0] vec);
    tag_t res;
    res = '0;
    for (int i = RS_NUM - 1; i >= 0; i--) begin
      if (vec[i]) res = tag_t'(i);
    end
    return res;
  endfunction
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic [RS_NUM-1:0] opsReady,
  input  logic              exAccept,
  output logic              exValid,
  input  logic [RS_NUM-1:0] doneReq,
  output rs_strobe_t        strb
);
  logic [RS_NUM-1:0] busy, started;
  logic [RS_NUM-1:0] freeVec, readyVec, reqVec;
  tag_t rrPtr, grantIdx;
  logic grantHit;

  always_comb begin
    freeVec  = ~busy;
    readyVec = busy & ~started & opsReady;
    reqVec   = doneReq & busy & started;
  end

  // round-robin search starting at rrPtr; lowest offset wins
  always_comb begin
    grantHit = 1'b0;
    grantIdx = rrPtr;
    for (int k = RS_NUM - 1; k >= 0; k--) begin
      if (reqVec[tag_t'((int'(rrPtr) + k) % RS_NUM)]) begin
        grantHit = 1'b1;
        grantIdx = tag_t'((int'(rrPtr) + k) % RS_NUM);
      end
    end
  end

  assign issueReady = |freeVec;
  assign exValid    = |readyVec;

  always_comb begin
    strb.alloc    = issueValid && issueReady;
    strb.allocIdx = lowestSet(freeVec);
    strb.bcast    = grantHit;
    strb.bcastIdx = grantIdx;
    strb.dispIdx  = lowestSet(readyVec);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= '0;
      started <= '0;
      rrPtr   <= '0;
    end else begin
      if (strb.bcast) begin
        busy[strb.bcastIdx]    <= 1'b0;
        started[strb.bcastIdx] <= 1'b0;
        rrPtr <= tag_t'((int'(strb.bcastIdx) + 1) % RS_NUM);
      end
      if (exValid && exAccept) started[strb.dispIdx] <= 1'b1;
      if (strb.alloc) begin
        busy[strb.allocIdx]    <= 1'b1;
        started[strb.allocIdx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rs_data.sv
module rs_data
  import rs_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  rs_strobe_t               strb,
  input  op_t                      issueOp,
  input  regIdx_t                  issueDst,
  input  regIdx_t                  issueSrcA,
  input  regIdx_t                  issueSrcB,
  input  logic [RS_NUM*DATA_W-1:0] doneData,
  output logic [RS_NUM-1:0]        opsReady,
  output word_t                    cdbValue,
  output op_t                      exOp,
  output word_t                    exVj,
  output word_t                    exVk
);
  op_t   stOp [RS_NUM];
  word_t stVj [RS_NUM];
  word_t stVk [RS_NUM];
  qtag_t stQj [RS_NUM];
  qtag_t stQk [RS_NUM];
  word_t regVal  [REG_NUM];
  qtag_t regStat [REG_NUM];

  qtag_t qa, qb, issQj, issQk;
  word_t issVj, issVk;
  logic  hitA, hitB;

  assign cdbValue = doneData[strb.bcastIdx*DATA_W +: DATA_W];

  // operand resolution at issue, with same-cycle bus bypass
  always_comb begin
    qa    = regStat[issueSrcA];
    qb    = regStat[issueSrcB];
    hitA  = strb.bcast && qa.pend && (qa.src == strb.bcastIdx);
    hitB  = strb.bcast && qb.pend && (qb.src == strb.bcastIdx);
    issVj = hitA ? cdbValue : regVal[issueSrcA];
    issVk = hitB ? cdbValue : regVal[issueSrcB];
    issQj = hitA ? '0 : qa;
    issQk = hitB ? '0 : qb;
  end

  for (genvar i = 0; i < RS_NUM; i++) begin : g_ready
    assign opsReady[i] = !stQj[i].pend && !stQk[i].pend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RS_NUM; i++) begin
        stOp[i] <= '0;
        stVj[i] <= '0;
        stVk[i] <= '0;
        stQj[i] <= '0;
        stQk[i] <= '0;
      end
    end else begin
      for (int i = 0; i < RS_NUM; i++) begin
        if (strb.alloc && strb.allocIdx == tag_t'(i)) begin
          stOp[i] <= issueOp;
          stVj[i] <= issVj;
          stVk[i] <= issVk;
          stQj[i] <= issQj;
          stQk[i] <= issQk;
        end else begin
          if (strb.bcast && stQj[i].pend && stQj[i].src == strb.bcastIdx) begin
            stVj[i] <= cdbValue;
            stQj[i] <= '0;
          end
          if (strb.bcast && stQk[i].pend && stQk[i].src == strb.bcastIdx) begin
            stVk[i] <= cdbValue;
            stQk[i] <= '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < REG_NUM; r++) begin
        regVal[r]  <= '0;
        regStat[r] <= '0;
      end
    end else begin
      for (int r = 0; r < REG_NUM; r++) begin
        if (strb.bcast && regStat[r].pend && regStat[r].src == strb.bcastIdx) begin
          regVal[r]  <= cdbValue;
          regStat[r] <= '0;
        end
        if (strb.alloc && issueDst == regIdx_t'(r)) begin
          regStat[r] <= '{pend: 1'b1, src: strb.allocIdx};
        end
      end
    end
  end

  assign exOp = stOp[strb.dispIdx];
  assign exVj = stVj[strb.dispIdx];
  assign exVk = stVk[strb.dispIdx];
endmodule

// File: rtl/tag_rs_pool.sv
module tag_rs_pool
  import rs_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     issueValid,
  input  logic [OP_W-1:0]          issueOp,
  input  logic [REG_W-1:0]         issueDst,
  input  logic [REG_W-1:0]         issueSrcA,
  input  logic [REG_W-1:0]         issueSrcB,
  output logic                     issueReady,
  output logic                     exValid,
  input  logic                     exAccept,
  output logic [TAG_W-1:0]         exTag,
  output logic [OP_W-1:0]          exOp,
  output logic [DATA_W-1:0]        exVj,
  output logic [DATA_W-1:0]        exVk,
  input  logic [RS_NUM-1:0]        doneReq,
  input  logic [RS_NUM*DATA_W-1:0] doneData,
  output logic                     cdbValid,
  output logic [TAG_W-1:0]         cdbTag,
  output logic [DATA_W-1:0]        cdbValue
);
  rs_strobe_t        strb;
  logic [RS_NUM-1:0] opsReady;

  rs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .issueReady(issueReady),
    .opsReady  (opsReady),
    .exAccept  (exAccept),
    .exValid   (exValid),
    .doneReq   (doneReq),
    .strb      (strb)
  );

  rs_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .issueOp  (issueOp),
    .issueDst (issueDst),
    .issueSrcA(issueSrcA),
    .issueSrcB(issueSrcB),
    .doneData (doneData),
    .opsReady (opsReady),
    .cdbValue (cdbValue),
    .exOp     (exOp),
    .exVj     (exVj),
    .exVk     (exVk)
  );

  assign exTag    = strb.dispIdx;
  assign cdbValid = strb.bcast;
  assign cdbTag   = strb.bcastIdx;
endmodule

// File: rtl/tag_rs_pool_chk.sv
module tag_rs_pool_chk
  import rs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic              issueReady,
  input logic              exValid,
  input logic              exAccept,
  input logic [TAG_W-1:0]  exTag,
  input logic [RS_NUM-1:0] doneReq,
  input logic              cdbValid,
  input logic [TAG_W-1:0]  cdbTag
);
  // stations the functional unit has accepted and not yet seen broadcast
  logic [RS_NUM-1:0] inFlight;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= '0;
    end else begin
      if (cdbValid) inFlight[cdbTag] <= 1'b0;
      if (exValid && exAccept) inFlight[exTag] <= 1'b1;
    end
  end

  p_bcast_only_inflight_r9: assert property (@(posedge clk) disable iff (!rstN)
    cdbValid |-> inFlight[cdbTag]);

  p_bcast_has_request_r8: assert property (@(posedge clk) disable iff (!rstN)
    cdbValid |-> doneReq[cdbTag]);

  p_request_served_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(doneReq & inFlight)) |-> cdbValid);

  p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (!rstN)
    cdbValid |=> !(cdbValid && cdbTag == $past(cdbTag)));

  p_offer_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && !exAccept) |=> exValid);

  p_full_after_issue_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(issueReady) |-> $past(issueValid));
endmodule

bind tag_rs_pool tag_rs_pool_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .issueValid(issueValid),
  .issueReady(issueReady),
  .exValid   (exValid),
  .exAccept  (exAccept),
  .exTag     (exTag),
  .doneReq   (doneReq),
  .cdbValid  (cdbValid),
  .cdbTag    (cdbTag)
);

// File: tb/tag_rs_pool_test.sv
`timescale 1ns/1ps
module tag_rs_pool_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [2:0]  issueOp, issueDst, issueSrcA, issueSrcB;
  logic        issueReady, exValid, exAccept, cdbValid;
  logic [1:0]  exTag, cdbTag;
  logic [2:0]  exOp;
  logic [31:0] exVj, exVk, cdbValue;
  logic [3:0]  doneReq;
  logic [127:0] doneData;

  int nChecks = 0;
  int nFail   = 0;
  logic [31:0] expReg [8];
  int expPtr;

  always #2.5 clk = ~clk;

  tag_rs_pool uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueReady(issueReady), .exValid(exValid), .exAccept(exAccept),
    .exTag(exTag), .exOp(exOp), .exVj(exVj), .exVk(exVk),
    .doneReq(doneReq), .doneData(doneData), .cdbValid(cdbValid),
    .cdbTag(cdbTag), .cdbValue(cdbValue)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic issueOne(input int dst, input int a, input int b);
    issueValid = 1'b1;
    issueOp    = 3'(dst);
    issueDst   = 3'(dst);
    issueSrcA  = 3'(a);
    issueSrcB  = 3'(b);
    cyc();
    issueValid = 1'b0;
  endtask

  // full round trip through station 0 when the pool is empty
  task automatic produce(input int dst, input logic [31:0] val, input int a, input int b);
    issueOne(dst, a, b);
    #1;
    chk("R7 offer after issue", exValid, 1);
    chk("R2 lowest free station", exTag, 0);
    chk("R3 srcA value", exVj, expReg[a]);
    chk("R3 srcB value", exVk, expReg[b]);
    chk("R3 op carried", exOp, 32'(dst));
    exAccept = 1'b1;
    cyc();
    exAccept = 1'b0;
    doneReq  = 4'b0001;
    doneData[31:0] = val;
    #1;
    chk("R8 bus valid", cdbValid, 1);
    chk("R8 bus tag", cdbTag, 0);
    chk("R8 bus value", cdbValue, val);
    cyc();
    doneReq = '0;
    expReg[dst] = val;
    expPtr = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] va, vb, vc;
    rstN = 1'b0; issueValid = 1'b0; issueOp = '0; issueDst = '0;
    issueSrcA = '0; issueSrcB = '0; exAccept = 1'b0; doneReq = '0; doneData = '0;
    for (int r = 0; r < 8; r++) expReg[r] = '0;
    expPtr = 0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    #1;
    chk("R1 issueReady", issueReady, 1);
    chk("R1 exValid", exValid, 0);
    chk("R1 cdbValid", cdbValid, 0);

    // R9: requests from free stations
    doneReq = 4'b1111;
    #1 chk("R9 idle request ignored", cdbValid, 0);
    doneReq = '0;
    cyc();
    // R9: busy but not accepted
    issueOne(1, 0, 0);
    doneReq = 4'b0001;
    doneData[31:0] = 32'h0BAD_0001;
    #1;
    chk("R9 unaccepted request ignored", cdbValid, 0);
    chk("R3 offered", exValid, 1);
    exAccept = 1'b1;
    cyc();
    exAccept = 1'b0;
    #1 chk("R9 accepted request served", cdbValid, 1);
    cyc();
    doneReq = '0;
    expReg[1] = 32'h0BAD_0001;
    expPtr = 1;

    // R1 zero registers and R3 value copy: first sweep
    for (int r = 0; r < 8; r++)
      produce(r, 32'hC0DE_0000 + 32'(r) * 32'h0101_0101, (r + 1) % 8, (r + 5) % 8);
    // near-exhaustive source pairs, results are sums
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        produce((a + b) % 8, expReg[a] + expReg[b], a, b);

    // R4: consumer waits on two producers
    va = 32'h1111_AAAA; vb = 32'h2222_BBBB; vc = 32'h3333_CCCC;
    issueOne(2, 0, 0);
    issueOne(3, 0, 0);
    issueOne(4, 2, 3);
    #1 chk("R7 lowest ready", exTag, 0);
    exAccept = 1'b1;
    cyc();
    #1 chk("R7 next ready after accept", exTag, 1);
    cyc();
    exAccept = 1'b0;
    #1 chk("R4 consumer waits", exValid, 0);
    doneReq = 4'b0001; doneData[31:0] = va;
    #1 chk("R8 tag producer0", cdbTag, 0);
    cyc();
    doneReq = '0;
    #1 chk("R4 still waits on second", exValid, 0);
    doneReq = 4'b0010; doneData[63:32] = vb;
    #1 chk("R8 tag producer1", cdbTag, 1);
    cyc();
    doneReq = '0;
    #1;
    chk("R4 woken", exValid, 1);
    chk("R4 woken tag", exTag, 2);
    chk("R4 captured Vj", exVj, va);
    chk("R4 captured Vk", exVk, vb);
    exAccept = 1'b1;
    cyc();
    exAccept = 1'b0;
    doneReq = 4'b0100; doneData[95:64] = vc;
    cyc();
    doneReq = '0;
    expReg[2] = va; expReg[3] = vb; expReg[4] = vc;
    produce(5, 32'h5555_0005, 2, 3);

    // R5: two writers of r6, younger broadcast first
    va = 32'hAAAA_0006; vb = 32'hBBBB_0006; vc = 32'hCCCC_0007;
    issueOne(6, 0, 0);
    issueOne(6, 0, 0);
    issueOne(7, 6, 6);
    exAccept = 1'b1;
    #1 chk("R7 older writer offered", exTag, 0);
    cyc();
    #1 chk("R7 younger writer offered", exTag, 1);
    cyc();
    exAccept = 1'b0;
    #1 chk("R5 reader waits on younger", exValid, 0);
    doneReq = 4'b0010; doneData[63:32] = vb;
    cyc();
    doneReq = '0;
    #1;
    chk("R5 reader woken by younger", exValid, 1);
    chk("R5 reader tag", exTag, 2);
    chk("R5 reader Vj", exVj, vb);
    chk("R5 reader Vk", exVk, vb);
    doneReq = 4'b0001; doneData[31:0] = va;
    #1 chk("R8 older writer granted", cdbTag, 0);
    cyc();
    doneReq = '0;
    exAccept = 1'b1;
    cyc();
    exAccept = 1'b0;
    doneReq = 4'b0100; doneData[95:64] = vc;
    cyc();
    doneReq = '0;
    expReg[6] = vb; expReg[7] = vc;
    produce(5, 32'h5555_0015, 6, 7);

    // R6: issue and producer broadcast in the same cycle
    va = 32'hFACE_0001; vb = 32'hFACE_0002;
    issueOne(1, 0, 0);
    exAccept = 1'b1;
    cyc();
    exAccept = 1'b0;
    issueValid = 1'b1; issueOp = 3'd2; issueDst = 3'd2; issueSrcA = 3'd1; issueSrcB = 3'd1;
    doneReq = 4'b0001; doneData[31:0] = va;
    #1 chk("R8 producer granted", cdbTag, 0);
    cyc();
    issueValid = 1'b0;
    doneReq = '0;
    #1;
    chk("R6 bypass ready", exValid, 1);
    chk("R6 bypass tag", exTag, 1);
    chk("R6 bypass Vj", exVj, va);
    chk("R6 bypass Vk", exVk, va);
    exAccept = 1'b1;
    cyc();
    exAccept = 1'b0;
    doneReq = 4'b0010; doneData[63:32] = vb;
    cyc();
    doneReq = '0;
    expReg[1] = va; expReg[2] = vb;
    produce(3, 32'h3333_0003, 1, 2);

    // R2 full pool, R8 round-robin with all requesting
    for (int i = 0; i < 4; i++) issueOne(i, 7, 7);
    #1 chk("R2 full pool", issueReady, 0);
    issueValid = 1'b1; issueOp = 3'd7; issueDst = 3'd7; issueSrcA = 3'd0; issueSrcB = 3'd0;
    cyc();
    issueValid = 1'b0;
    exAccept = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1 chk("R7 dispatch order", exTag, 32'(i));
      cyc();
    end
    exAccept = 1'b0;
    #1 chk("R2 no extra station from stalled issue", exValid, 0);
    doneReq = 4'b1111;
    for (int i = 0; i < 4; i++) doneData[i*32 +: 32] = 32'h5000_0000 + 32'(i);
    for (int k = 0; k < 4; k++) begin
      int g;
      g = (expPtr + k) % 4;
      #1;
      chk("R8 round-robin tag", cdbTag, 32'(g));
      chk("R8 round-robin value", cdbValue, 32'h5000_0000 + 32'(g));
      cyc();
      doneReq[g] = 1'b0;
      expReg[g] = 32'h5000_0000 + 32'(g);
      if (k == 0) begin
        #1 chk("R2 freed after broadcast", issueReady, 1);
      end
    end
    produce(5, 32'h5555_0025, 7, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule